// File: doc/BRIEF.md
# DRAM Array Strobe Sequencer

This block drives the internal control strobes of one memory array: bit-line precharge, word line enable, bit-line select, sense-amplifier enable and column select. A requester presents an operation code with a row and a column index. The block steps through the strobe order for that operation and then pulses `done`. Each phase lasts a number of clock cycles set by a parameter.

The three operations use different strobe orders. A read equalizes the bit lines, opens the word line, senses the row, and only then gates the chosen column out. A write loads the sense amplifier through the column path before any word line opens. A refresh senses and restores a row and never touches the column path.

A cycle-level behavioural array model stands in for the storage cells. Sensing with the word line open copies the row into the sense amplifiers and restores it. A write drives the loaded sense-amplifier bit back into the selected cell. A read returns the sensed bit one cycle after column select.

Top module: `cell_strobe_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every strobe, `busy`, `done` and `rd_valid` are low.
- R2: Once a read (`req_op` = 00) is accepted, the block drives the following sequence from the next cycle on. First precharge alone for T_PRE cycles. Then word line and bit-line select for T_SHARE cycles with the sense amp off. Then word line, bit-line select and sense amp for T_SENSE cycles. Then one cycle with those three plus column select. Then one cycle with every strobe low and `done` high.
- R3: `rd_valid` is high for exactly one cycle, the cycle after column select of a read. In that cycle `rd_data` equals the bit last written to the addressed cell.
- R4: Precharge is never high in the same cycle as the word line.
- R5: Once a write (`req_op` = 01) is accepted, the block drives the following sequence. One cycle of column select alone. Then one cycle of column select with sense amp. Then T_SHARE cycles of word line, bit-line select and sense amp. Then one cycle with every strobe low and `done` high. Only the addressed cell takes `req_wdata`; every other cell keeps its value.
- R6: A refresh (`req_op` = 10) follows the read order but has no column-select cycle. Its `done` cycle comes right after sensing. It never raises `rd_valid`, and it leaves every stored bit unchanged.
- R7: A request is taken only when `busy` is low. A request made while `busy` is high is ignored, and so is `req_op` = 11. Neither changes the strobes or any stored bit.
- R8: `busy` is high from the cycle after acceptance up to and including the single `done` cycle, and low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 00 read, 01 write, 10 refresh, 11 none |
| req_row | input | ROW_W | Row index |
| req_col | input | COL_W | Column index |
| req_wdata | input | 1 | Bit to store on a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pre_en | output | 1 | Bit-line precharge |
| wl_en | output | 1 | Word line enable |
| bsel_en | output | 1 | Bit-line select |
| sa_en | output | 1 | Sense-amplifier enable |
| csel_en | output | 1 | Column select |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 1 | Bit read from the array |

## Verification
Every cell of an 8x8 array is written with an arithmetic pattern and then read back. Each cycle of every operation is compared with the strobe vector expected for its phase index, so a wrong phase length or a wrong strobe order shows up in the cycle where it happens. The pattern is then changed on the diagonal and every row is refreshed before a second full read pass. This separates a refresh that corrupts or reorders a row from a write that spills into neighbouring cells. During some reads a write request is injected while the block is busy, and an op code of 11 is offered while idle. Checking the affected cells afterwards shows that neither request reached the array.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_REFRESH = 2'b10,
    OP_NONE    = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SHARE,
    ST_SENSE,
    ST_COLRD,
    ST_WLOAD,
    ST_WLATCH,
    ST_WDRIVE,
    ST_DONE
  } st_e;

  typedef struct packed {
    logic pre;
    logic wl;
    logic bsel;
    logic sa;
    logic csel;
  } strobe_t;

endpackage

// File: rtl/csq_phase_timer.sv
module csq_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/csq_fsm.sv
module csq_fsm
  import csq_pkg::*;
#(
  parameter int T_PRE   = 2,
  parameter int T_SHARE = 2,
  parameter int T_SENSE = 3,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  op_e              req_op,
  input  logic             phase_last,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output op_e              op_q,
  output strobe_t          strb,
  output logic             busy,
  output logic             done
);

  st_e state_q, state_d;
  op_e op_d;

  // Length of a phase minus one, loaded into the timer on entry
  function automatic logic [CNT_W-1:0] phase_len(input st_e st);
    case (st)
      ST_PRE:    phase_len = CNT_W'(T_PRE - 1);
      ST_SHARE:  phase_len = CNT_W'(T_SHARE - 1);
      ST_SENSE:  phase_len = CNT_W'(T_SENSE - 1);
      ST_WDRIVE: phase_len = CNT_W'(T_SHARE - 1);
      default:   phase_len = '0;
    endcase
  endfunction

  assign accept = (state_q == ST_IDLE) && req_valid && (req_op != OP_NONE);

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_d    = req_op;
          state_d = (req_op == OP_WRITE) ? ST_WLOAD : ST_PRE;
        end
      end
      ST_PRE:    if (phase_last) state_d = ST_SHARE;
      ST_SHARE:  if (phase_last) state_d = ST_SENSE;
      ST_SENSE: begin
        if (phase_last) state_d = (op_q == OP_READ) ? ST_COLRD : ST_DONE;
      end
      ST_COLRD:  state_d = ST_DONE;
      ST_WLOAD:  state_d = ST_WLATCH;
      ST_WLATCH: state_d = ST_WDRIVE;
      ST_WDRIVE: if (phase_last) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign timer_load = (state_d != state_q);
  assign timer_val  = phase_len(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
    end
  end

  // Strobe decode per state
  always_comb begin
    strb = '0;
    unique case (state_q)
      ST_PRE:    strb.pre = 1'b1;
      ST_SHARE:  begin strb.wl = 1'b1; strb.bsel = 1'b1; end
      ST_SENSE:  begin strb.wl = 1'b1; strb.bsel = 1'b1; strb.sa = 1'b1; end
      ST_COLRD:  begin
        strb.wl = 1'b1; strb.bsel = 1'b1; strb.sa = 1'b1; strb.csel = 1'b1;
      end
      ST_WLOAD:  strb.csel = 1'b1;
      ST_WLATCH: begin strb.csel = 1'b1; strb.sa = 1'b1; end
      ST_WDRIVE: begin strb.wl = 1'b1; strb.bsel = 1'b1; strb.sa = 1'b1; end
      default:   strb = '0;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);

endmodule

// File: rtl/csq_cell_array.sv
module csq_cell_array
  import csq_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             wr_bit,
  output logic             rd_valid,
  output logic             rd_bit
);

  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [COLS-1:0] cells_q [ROWS];
  logic [COLS-1:0] amp_q, amp_d;
  logic            sa_prev_q;
  logic            wmode_q, wmode_d;
  logic            rd_valid_d, rd_bit_d;

  logic sa_rise, sense_evt, load_evt, drive_evt, col_evt;

  assign sa_rise   = strb.sa && !sa_prev_q;
  // Row sensed into the amplifiers with the word line open (restores cells)
  assign sense_evt = sa_rise && strb.wl;
  // Column path loads the amplifier while no word line is open
  assign load_evt  = strb.csel && !strb.wl;
  // Amplifier loaded first, then word line opened: it drives the cell
  assign drive_evt = wmode_q && strb.wl && strb.bsel && strb.sa;
  // Sensed value gated onto the I/O lines
  assign col_evt   = strb.csel && strb.wl && strb.sa;

  always_comb begin
    amp_d = amp_q;
    if (sense_evt) begin
      amp_d = cells_q[row];
    end else if (load_evt) begin
      amp_d[col] = wr_bit;
    end
    if (!strb.sa) begin
      wmode_d = 1'b0;
    end else if (sa_rise && !strb.wl) begin
      wmode_d = 1'b1;
    end else begin
      wmode_d = wmode_q;
    end
    rd_valid_d = col_evt;
    rd_bit_d   = col_evt ? amp_q[col] : rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q     <= '0;
      sa_prev_q <= 1'b0;
      wmode_q   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_bit    <= 1'b0;
    end else begin
      amp_q     <= amp_d;
      sa_prev_q <= strb.sa;
      wmode_q   <= wmode_d;
      rd_valid  <= rd_valid_d;
      rd_bit    <= rd_bit_d;
    end
  end

  // Storage cells carry no reset
  always_ff @(posedge clk) begin
    if (drive_evt) begin
      cells_q[row][col] <= amp_q[col];
    end
  end

endmodule

// File: rtl/cell_strobe_seq.sv
module cell_strobe_seq
  import csq_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int T_PRE   = 2,
  parameter int T_SHARE = 2,
  parameter int T_SENSE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_wdata,
  output logic             busy,
  output logic             done,
  output logic             pre_en,
  output logic             wl_en,
  output logic             bsel_en,
  output logic             sa_en,
  output logic             csel_en,
  output logic             rd_valid,
  output logic             rd_data
);

  localparam int T_MAX1 = (T_PRE > T_SHARE) ? T_PRE : T_SHARE;
  localparam int T_MAX  = (T_MAX1 > T_SENSE) ? T_MAX1 : T_SENSE;
  localparam int CNT_W  = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  logic             accept, timer_load, phase_last;
  logic [CNT_W-1:0] timer_val;
  op_e              op_q;
  logic [1:0]       op_cur;
  strobe_t          strb;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             wd_q, wd_d;

  assign op_cur = op_q;

  csq_fsm #(
    .T_PRE   (T_PRE),
    .T_SHARE (T_SHARE),
    .T_SENSE (T_SENSE),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (op_e'(req_op)),
    .phase_last (phase_last),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .op_q       (op_q),
    .strb       (strb),
    .busy       (busy),
    .done       (done)
  );

  csq_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .last     (phase_last)
  );

  // Address and data captured with a clock enable on acceptance
  always_comb begin
    row_d = accept ? req_row   : row_q;
    col_d = accept ? req_col   : col_q;
    wd_d  = accept ? req_wdata : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      wd_q  <= 1'b0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      wd_q  <= wd_d;
    end
  end

  csq_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .row      (row_q),
    .col      (col_q),
    .wr_bit   (wd_q),
    .rd_valid (rd_valid),
    .rd_bit   (rd_data)
  );

  assign pre_en  = strb.pre;
  assign wl_en   = strb.wl;
  assign bsel_en = strb.bsel;
  assign sa_en   = strb.sa;
  assign csel_en = strb.csel;

endmodule

// File: rtl/csq_checker.sv
module csq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pre,
  input logic       wl,
  input logic       bsel,
  input logic       sa,
  input logic       csel,
  input logic       done,
  input logic       busy,
  input logic       rd_valid,
  input logic [1:0] op_q
);

  p_pre_wl_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre && wl));

  p_col_after_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csel && wl) |-> (sa && $past(sa)));

  p_sense_after_share_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sa) && wl) |-> $past(wl && bsel));

  p_rdvalid_follows_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(csel && wl));

  p_wr_load_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wl) && sa) |-> $past(csel && sa));

  p_refresh_no_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == 2'b10) |-> !csel);

  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

bind cell_strobe_seq csq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pre      (pre_en),
  .wl       (wl_en),
  .bsel     (bsel_en),
  .sa       (sa_en),
  .csel     (csel_en),
  .done     (done),
  .busy     (busy),
  .rd_valid (rd_valid),
  .op_q     (op_cur)
);

// File: tb/cell_strobe_seq_tb.sv
module cell_strobe_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int CW = 3;
  localparam int TP = 2;
  localparam int TS = 2;
  localparam int TN = 3;
  localparam int NR = 1 << RW;
  localparam int NC = 1 << CW;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_wdata;
  logic [1:0] req_op;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic busy, done, pre_en, wl_en, bsel_en, sa_en, csel_en, rd_valid, rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [NC-1:0] mdl [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_strobe_seq #(
    .ROW_W(RW), .COL_W(CW), .T_PRE(TP), .T_SHARE(TS), .T_SENSE(TN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .busy(busy), .done(done), .pre_en(pre_en), .wl_en(wl_en),
    .bsel_en(bsel_en), .sa_en(sa_en), .csel_en(csel_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic bit pat(int r, int c, int seed);
    return bit'(((r * 5 + c * 3 + seed) >> 1) & 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected {pre,wl,bsel,sa,csel,done,busy} in cycle k after acceptance
  function automatic logic [6:0] exp_vec(int op, int k);
    if (op == 1) begin
      if (k == 1)          return 7'b0000101;
      if (k == 2)          return 7'b0001101;
      if (k <= 2 + TS)     return 7'b0111001;
      return 7'b0000011;
    end
    if (k <= TP)           return 7'b1000001;
    if (k <= TP + TS)      return 7'b0110001;
    if (k <= TP + TS + TN) return 7'b0111001;
    if (op == 0 && k == TP + TS + TN + 1) return 7'b0111101;
    return 7'b0000011;
  endfunction

  task automatic run_op(int op, int r, int c, bit wd, bit inject);
    int len;
    string tag;
    logic [6:0] act, exp;
    len = (op == 1) ? TS + 3 : (op == 0) ? TP + TS + TN + 2 : TP + TS + TN + 1;
    tag = (op == 0) ? "R2" : (op == 1) ? "R5" : "R6";
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op);
    req_row = RW'(r); req_col = CW'(c); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= len; k++) begin
      act = {pre_en, wl_en, bsel_en, sa_en, csel_en, done, busy};
      exp = exp_vec(op, k);
      chk(act == exp, tag, $sformatf("strobes cycle %0d", k), int'(act), int'(exp));
      if (op == 0 && k == len) begin
        chk(rd_valid && rd_data == mdl[r][c], "R3", "read data {valid,bit}",
            int'({rd_valid, rd_data}), int'({1'b1, mdl[r][c]}));
      end else begin
        chk(!rd_valid, (op == 2) ? "R6" : "R3", "rd_valid idle", int'(rd_valid), 0);
      end
      // R7: a write offered while busy must be dropped
      if (inject && k == 2) begin
        req_valid = 1'b1; req_op = 2'b01;
        req_row = RW'(r ^ 1); req_col = CW'(c); req_wdata = ~mdl[r ^ 1][c];
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(!busy && !done, "R8", "busy/done after done", int'({busy, done}), 0);
    if (op == 1) mdl[r][c] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00;
    req_row = '0; req_col = '0; req_wdata = 1'b0;
    repeat (3) @(negedge clk);
    chk({pre_en, wl_en, bsel_en, sa_en, csel_en, done, busy, rd_valid} == 8'h00,
        "R1", "outputs in reset",
        int'({pre_en, wl_en, bsel_en, sa_en, csel_en, done, busy, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pre_en, wl_en, bsel_en, sa_en, csel_en, done, busy, rd_valid} == 8'h00,
        "R1", "outputs after reset",
        int'({pre_en, wl_en, bsel_en, sa_en, csel_en, done, busy, rd_valid}), 0);

    // R5: fill every cell
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        run_op(1, r, c, pat(r, c, 0), 1'b0);

    // R2 R3 R7: read every cell, injecting busy-time writes on the diagonal
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        run_op(0, r, c, 1'b0, (r == c));

    // R7: op code 11 while idle is ignored
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b11; req_row = '0; req_col = '0; req_wdata = ~mdl[0][0];
      @(negedge clk);
      req_valid = 1'b0;
      chk(!busy && !pre_en && !csel_en, "R7", "no-op request started",
          int'({busy, pre_en, csel_en}), 0);
    end

    // R5: flip the diagonal, then R6: refresh every row
    for (int r = 0; r < NR; r++)
      run_op(1, r, r, ~mdl[r][r], 1'b0);
    for (int r = 0; r < NR; r++)
      run_op(2, r, 0, 1'b0, 1'b0);

    // R3 R6: full read after refresh
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        run_op(0, r, c, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule